// File: doc/BRIEF.md
# Bounded Backoff Delay Generator

This block sits between a lock requester and the bus. When the requester sees that a lock has been freed, it pulses `release_i`. The block then waits a number of slots, each `slot_len_i` clock cycles long, and pulses `go_o` for one cycle. On that pulse the requester issues its atomic test-and-set. Spreading the requesters out in time this way cuts the number of atomic attempts that fail. No delay is added while the lock holder is inside its critical section. The wait starts only after a release is seen.

There are two ways to pick the number of slots. In static mode, each requester has a fixed slot position, checked against a slot count that can be changed at run time. In dynamic mode, the block keeps a backoff window of 2^e slots. Every failed attempt doubles the window, up to a programmable ceiling. A successful acquire returns the window to a single slot. The wait is a pseudo-random slot count below the window, taken from a free-running LFSR. The lock itself is not part of this block.

Top module: `backoff_delay_gen`

## Requirements
- R1: After reset, `go_o` is low and the dynamic window exponent e is 0, so the first dynamic wait is 0 slots.
- R2: With a wait of S slots and an effective slot length L, `go_o` is high during the cycle that follows the (S·L+1)-th rising edge after the edge that samples `release_i`.
- R3: When `mode_i`=0 (static), S equals `slot_idx_i`. If `slot_idx_i` ≥ `num_slots_i`, S is clamped to `num_slots_i`−1. A `num_slots_i` of 0 acts as 1.
- R4: A `slot_len_i` of 0 acts as a slot length of 1 cycle.
- R5: `go_o` is high for exactly one cycle per expired countdown and never while a countdown is running. Without `release_i`, `fail_i` and `success_i` produce no `go_o`.
- R6: A `release_i` that arrives during a running countdown discards it and starts a new countdown from that edge.
- R7: When `mode_i`=1 (dynamic), S is a pseudo-random value in the range 0 to 2^e−1.
- R8: Each `fail_i` pulse raises e by one, up to min(`bound_exp_i`, SLOT_W−1), with SLOT_W = 8 by default. Lowering `bound_exp_i` clamps e at once.
- R9: A `success_i` pulse returns e to 0. If `success_i` and `fail_i` are high in the same cycle, `success_i` wins.
- R10: In static mode, the wait does not depend on the failures or successes recorded in the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| release_i | input | 1 | Pulse: a lock release was detected; start the countdown |
| fail_i | input | 1 | Pulse: the last atomic attempt failed |
| success_i | input | 1 | Pulse: the last atomic attempt acquired the lock |
| mode_i | input | 1 | 0 = static slot mode, 1 = dynamic backoff mode |
| slot_idx_i | input | SLOT_W | Static slot position of this requester |
| num_slots_i | input | SLOT_W | Number of static slots in use |
| slot_len_i | input | LEN_W | Cycles per slot |
| bound_exp_i | input | EXP_W | Ceiling on the window exponent |
| go_o | output | 1 | One-cycle pulse: attempt the test-and-set now |

## Verification
If the window exponent is wrong, nothing shows until the next dynamic countdown. There it appears as a wait that is longer than 2^e slots, or as a spread of waits that is too narrow. Finding it therefore takes several release/go rounds, and the bench gathers many samples for each window size. Errors in the slot or tick counters show up within a single countdown, as a `go_o` edge that falls on the wrong cycle or lasts more than one cycle. A stuck active flag shows up as a missing `go_o` or a spurious one.

// File: rtl/bdg_pkg.sv
package bdg_pkg;
  typedef enum logic {
    MODE_STATIC  = 1'b0,
    MODE_DYNAMIC = 1'b1
  } bdg_mode_e;
endpackage

// File: rtl/bdg_rst_sync.sv
module bdg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bdg_lfsr.sv
module bdg_lfsr #(
  parameter int              WIDTH = 16,
  parameter logic [WIDTH-1:0] TAPS = 16'hB400,
  parameter logic [WIDTH-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [WIDTH-1:0] state_o
);
  logic [WIDTH-1:0] state_q, state_d;

  always_comb begin
    state_d = state_q >> 1;
    if (state_q[0]) state_d = state_d ^ TAPS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0); // R7
endmodule

// File: rtl/bdg_window.sv
module bdg_window #(
  parameter int EXP_W   = 3,
  parameter int MAX_EXP = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fail_i,
  input  logic             success_i,
  input  logic [EXP_W-1:0] bound_i,
  output logic [EXP_W-1:0] exp_o
);
  localparam logic [EXP_W-1:0] MAX_E = EXP_W'(MAX_EXP);

  logic [EXP_W-1:0] exp_q, exp_d, limit, exp_eff;
  logic             exp_en;

  always_comb begin
    limit   = (bound_i > MAX_E) ? MAX_E : bound_i;
    exp_eff = (exp_q > limit) ? limit : exp_q;
    exp_en  = success_i | fail_i;
    exp_d   = exp_q;
    if (success_i)             exp_d = '0;
    else if (exp_eff < limit)  exp_d = exp_eff + 1'b1;
    else                       exp_d = limit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      exp_q <= '0;
    else if (exp_en) exp_q <= exp_d;
  end

  assign exp_o = exp_eff;

  AST_WIN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    success_i |=> exp_q == '0); // R9
  AST_WIN_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_i && !success_i && exp_eff < limit) |=> exp_q == $past(exp_eff) + 1'b1); // R8
  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fail_i && !success_i) |=> $stable(exp_q)); // R8
endmodule

// File: rtl/bdg_countdown.sv
module bdg_countdown #(
  parameter int SLOT_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [SLOT_W-1:0] slots_i,
  input  logic [LEN_W-1:0]  slot_len_i,
  output logic              go_o,
  output logic              active_o
);
  logic              active_q, active_d;
  logic [SLOT_W-1:0] slots_q, slots_d;
  logic [LEN_W-1:0]  tick_q, tick_d, tick_last;
  logic              go_q, go_d;

  always_comb begin
    tick_last = (slot_len_i == '0) ? '0 : slot_len_i - 1'b1;
    active_d  = active_q;
    slots_d   = slots_q;
    tick_d    = tick_q;
    go_d      = 1'b0;
    if (load_i) begin
      active_d = 1'b1;
      slots_d  = slots_i;
      tick_d   = '0;
    end else if (active_q) begin
      if (slots_q == '0) begin
        active_d = 1'b0;
        go_d     = 1'b1;
      end else if (tick_q >= tick_last) begin
        tick_d  = '0;
        slots_d = slots_q - 1'b1;
      end else begin
        tick_d = tick_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      slots_q  <= '0;
      tick_q   <= '0;
      go_q     <= 1'b0;
    end else begin
      active_q <= active_d;
      slots_q  <= slots_d;
      tick_q   <= tick_d;
      go_q     <= go_d;
    end
  end

  assign go_o     = go_q;
  assign active_o = active_q;

  AST_GO_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> !active_q); // R5
  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |=> !go_q); // R5
  AST_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && slots_q == '0 && !load_i) |=> go_q); // R2
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (active_q && !go_q && slots_q == $past(slots_i))); // R6
endmodule

// File: rtl/backoff_delay_gen.sv
module backoff_delay_gen #(
  parameter int SLOT_W = 8,
  parameter int LEN_W  = 8,
  parameter int EXP_W  = 3,
  parameter int LFSR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              release_i,
  input  logic              fail_i,
  input  logic              success_i,
  input  logic              mode_i,
  input  logic [SLOT_W-1:0] slot_idx_i,
  input  logic [SLOT_W-1:0] num_slots_i,
  input  logic [LEN_W-1:0]  slot_len_i,
  input  logic [EXP_W-1:0]  bound_exp_i,
  output logic              go_o
);
  import bdg_pkg::*;

  localparam int MAX_EXP = SLOT_W - 1;

  logic              rst_s_n;
  logic [LFSR_W-1:0] lfsr;
  logic [EXP_W-1:0]  exp_cur;
  logic [SLOT_W-1:0] n_eff, static_slots, dyn_mask, dyn_slots, load_slots;
  logic              active;
  bdg_mode_e         mode;

  bdg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  bdg_lfsr #(.WIDTH(LFSR_W)) u_lfsr (
    .clk(clk), .rst_n(rst_s_n), .state_o(lfsr)
  );

  bdg_window #(.EXP_W(EXP_W), .MAX_EXP(MAX_EXP)) u_win (
    .clk(clk), .rst_n(rst_s_n), .fail_i(fail_i), .success_i(success_i),
    .bound_i(bound_exp_i), .exp_o(exp_cur)
  );

  always_comb begin
    mode         = bdg_mode_e'(mode_i);
    n_eff        = (num_slots_i == '0) ? SLOT_W'(1) : num_slots_i;
    static_slots = (slot_idx_i >= n_eff) ? n_eff - 1'b1 : slot_idx_i;
    dyn_mask     = ~({SLOT_W{1'b1}} << exp_cur);
    dyn_slots    = lfsr[SLOT_W-1:0] & dyn_mask;
    load_slots   = (mode == MODE_DYNAMIC) ? dyn_slots : static_slots;
  end

  bdg_countdown #(.SLOT_W(SLOT_W), .LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .load_i(release_i), .slots_i(load_slots),
    .slot_len_i(slot_len_i), .go_o(go_o), .active_o(active)
  );

  AST_DYN_BELOW_WIN: assert property (@(posedge clk) disable iff (!rst_s_n)
    (release_i && mode_i) |-> (32'(load_slots) < (32'd1 << exp_cur))); // R7
  AST_STATIC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (release_i && !mode_i) |-> (load_slots < n_eff)); // R3
  AST_WIN_CAP: assert property (@(posedge clk) disable iff (!rst_s_n)
    exp_cur <= bound_exp_i); // R8
  AST_GO_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_s_n)
    go_o |-> !active); // R5
endmodule

// File: tb/backoff_delay_gen_tb_top.sv
module backoff_delay_gen_tb_top;
  logic       clk, rst_n;
  logic       release_i, fail_i, success_i, mode_i;
  logic [7:0] slot_idx_i, num_slots_i, slot_len_i;
  logic [2:0] bound_exp_i;
  logic       go_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  backoff_delay_gen dut_i (
    .clk(clk), .rst_n(rst_n), .release_i(release_i), .fail_i(fail_i),
    .success_i(success_i), .mode_i(mode_i), .slot_idx_i(slot_idx_i),
    .num_slots_i(num_slots_i), .slot_len_i(slot_len_i),
    .bound_exp_i(bound_exp_i), .go_o(go_o)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pulse release and return the number of negedges until go_o is seen
  // (S*L+2 by R2); also checks that go lasts a single cycle (R5).
  task automatic measure(output int j);
    @(negedge clk); release_i = 1;
    @(negedge clk); release_i = 0; j = 1;
    while (!go_o && j < 3000) begin
      @(negedge clk); j++;
    end
    @(negedge clk);
    chk(!go_o, "R5 single-cycle go", go_o, 0);
  endtask

  task automatic pulse_fail(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); fail_i = 1;
      @(negedge clk); fail_i = 0;
    end
  endtask

  task automatic pulse_success();
    @(negedge clk); success_i = 1;
    @(negedge clk); success_i = 0;
  endtask

  task automatic t_reset();
    chk(go_o == 0, "R1 go low after reset", go_o, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (go_o) chk(0, "R1 idle go", 1, 0);
    end
    begin
      int j;
      mode_i = 1; slot_len_i = 3;
      measure(j);
      chk(j == 2, "R1 first dynamic wait zero", j, 2);
    end
  endtask

  task automatic t_static();
    int j;
    mode_i = 0; num_slots_i = 8; slot_len_i = 4;
    slot_idx_i = 0; measure(j); chk(j == 2, "R2 static slot0", j, 2);
    slot_idx_i = 3; measure(j); chk(j == 14, "R2 static slot3 L4", j, 14);
    slot_len_i = 1; slot_idx_i = 5; measure(j); chk(j == 7, "R2 static slot5 L1", j, 7);
    slot_len_i = 2; num_slots_i = 4; slot_idx_i = 9; measure(j);
    chk(j == 8, "R3 clamp to num_slots-1", j, 8);
    num_slots_i = 0; slot_idx_i = 6; measure(j);
    chk(j == 2, "R3 zero slots acts as one", j, 2);
    num_slots_i = 8; slot_idx_i = 4; slot_len_i = 0; measure(j);
    chk(j == 6, "R4 zero slot length", j, 6);
  endtask

  task automatic t_restart();
    int j;
    bit early;
    early = 0;
    mode_i = 0; num_slots_i = 8; slot_idx_i = 5; slot_len_i = 4;
    @(negedge clk); release_i = 1;
    @(negedge clk); release_i = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (go_o) early = 1;
    end
    measure(j);
    chk(!early, "R6 no go before restart", early, 0);
    chk(j == 22, "R6 restart countdown", j, 22);
  endtask

  task automatic t_no_spurious();
    bit seen;
    seen = 0;
    fork
      begin
        pulse_fail(2);
        pulse_success();
      end
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (go_o) seen = 1;
      end
    join
    chk(!seen, "R5 no go without release", seen, 0);
  endtask

  // Samples dynamic waits; returns max slot count and whether all were aligned and below window.
  task automatic sample_dyn(input int win, input int n, output int mx, output bit ok);
    int j, s;
    mx = 0; ok = 1;
    mode_i = 1; slot_len_i = 3;
    for (int i = 0; i < n; i++) begin
      measure(j);
      s = (j - 2) / 3;
      if (((j - 2) % 3) != 0 || s >= win || j < 2) ok = 0;
      if (s > mx) mx = s;
      repeat (i % 3) @(negedge clk);
    end
  endtask

  task automatic t_dynamic();
    int mx, j;
    bit ok;
    bound_exp_i = 7;
    pulse_success();
    pulse_fail(3);
    sample_dyn(8, 16, mx, ok);
    chk(ok, "R7 dynamic wait below window 8", mx, 7);
    chk(mx >= 4, "R8 window doubled to 8", mx, 4);
    bound_exp_i = 2;
    pulse_fail(6);
    sample_dyn(4, 16, mx, ok);
    chk(ok, "R8 capped window 4", mx, 3);
    chk(mx >= 2, "R8 capped window reached", mx, 2);
    bound_exp_i = 5;
    pulse_fail(5);
    bound_exp_i = 1;
    sample_dyn(2, 12, mx, ok);
    chk(ok, "R8 lowered bound clamps", mx, 1);
    bound_exp_i = 7;
    pulse_fail(4);
    pulse_success();
    mode_i = 1; slot_len_i = 3;
    measure(j); chk(j == 2, "R9 success resets window", j, 2);
    pulse_fail(4);
    @(negedge clk); fail_i = 1; success_i = 1;
    @(negedge clk); fail_i = 0; success_i = 0;
    measure(j); chk(j == 2, "R9 success wins over fail", j, 2);
  endtask

  task automatic t_static_ignores_window();
    int j;
    bound_exp_i = 7;
    pulse_fail(5);
    mode_i = 0; num_slots_i = 8; slot_idx_i = 2; slot_len_i = 3;
    measure(j); chk(j == 8, "R10 static unaffected by window", j, 8);
  endtask

  initial begin
    rst_n = 0; release_i = 0; fail_i = 0; success_i = 0; mode_i = 0;
    slot_idx_i = 0; num_slots_i = 8; slot_len_i = 1; bound_exp_i = 7;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_static();
    t_restart();
    t_no_spurious();
    t_dynamic();
    t_static_ignores_window();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule